// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

The block is a single timer channel with a word-addressed register window. Software loads a start count and a reload interval, then turns the counter on. Control fields pick the tick source, a power-of-two prescale and the mode: one-shot or auto-reload. The counter steps down once for each prescaled tick. When it reaches zero, a sticky pending flag is raised. The interrupt line is that flag masked by an enable register.

In auto-reload mode, the tick after zero loads the interval value again. In one-shot mode, that tick clears the run bit instead, and the counter rests at zero. The current count can be rewritten at any time. Software uses this to make the first expiry differ from the later period.

The two tick inputs are single-cycle clock enables in the timer's own clock domain. Register reads are combinational from the address. Writes take effect at the next rising clock edge.

Top module: `interval_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The register map uses these byte offsets: 0x00 interrupt enable (bit 0), 0x04 pending status (bit 0), 0x10 control, 0x14 reload interval, 0x18 current count. The control register holds run in bit 0, auto-reload in bit 1, fast-source select in bit 2, and the prescale code in bits 6:4. Written values read back, and an unmapped offset reads zero.
- R3: While run is set, the count drops by one on each prescaled tick, and it holds when no prescaled tick occurs. While run is clear, the count never changes except by a direct write.
- R4: A prescale code N passes one prescaled tick for every 2^N ticks of the selected source, so code 0 passes every tick. The prescale phase restarts from zero whenever run is clear.
- R5: With control bit 2 set, only `tick_fast` advances the timer. With it clear, only `tick_slow` does. The unselected input has no effect.
- R6: A prescaled tick that takes the count from 1 to 0 sets the pending status bit.
- R7: In auto-reload mode, a prescaled tick seen at count 0 loads the interval value, and run stays set. The period is therefore interval+1 ticks.
- R8: In one-shot mode, a prescaled tick seen at count 0 clears run (control bit 0), and the count stays at 0.
- R9: `irq` is high exactly when the pending bit and interrupt-enable bit 0 are both set.
- R10: Writing 1 to status bit 0 clears the pending flag, and writing 0 leaves it unchanged. If an expiry and a clearing write fall in the same cycle, the flag ends up set.
- R11: A write to the current-count register overrides a same-cycle decrement. A first count that differs from the interval gives a first expiry that differs from the period.
- R12: Reading the current-count register returns the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational from `bus_addr` |
| tick_slow | input | 1 | Slow-source clock-enable tick |
| tick_fast | input | 1 | Fast-source clock-enable tick |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench builds the block with its defaults: a 32-bit count and a 3-bit prescale code. Every tick is a single cycle driven by the bench, so each decrement, reload and stop can be placed on a known edge. Prescale code 2 puts the four-tick boundary within a handful of pulses. Same-cycle collisions are driven directly: a count write against a tick, and a status clear against an expiry. This exposes the priority rules without long runs.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int unsigned REG_AW = 8;

    localparam logic [REG_AW-1:0] OFS_IE   = 8'h00;
    localparam logic [REG_AW-1:0] OFS_STAT = 8'h04;
    localparam logic [REG_AW-1:0] OFS_CTRL = 8'h10;
    localparam logic [REG_AW-1:0] OFS_IVAL = 8'h14;
    localparam logic [REG_AW-1:0] OFS_CUR  = 8'h18;

    // control bit positions
    localparam int unsigned CB_RUN     = 0;
    localparam int unsigned CB_RELOAD  = 1;
    localparam int unsigned CB_FAST    = 2;
    localparam int unsigned CB_PRE_LSB = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IE,
        SEL_STAT,
        SEL_CTRL,
        SEL_IVAL,
        SEL_CUR
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [REG_AW-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_IE:   s = SEL_IE;
            OFS_STAT: s = SEL_STAT;
            OFS_CTRL: s = SEL_CTRL;
            OFS_IVAL: s = SEL_IVAL;
            OFS_CUR:  s = SEL_CUR;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
    parameter int unsigned PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             use_fast,
    input  logic [PRE_W-1:0] pre_code,
    input  logic             tick_slow,
    input  logic             tick_fast,
    output logic             pre_tick
);
    localparam int unsigned DIV_W = (1 << PRE_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } state_t;

    state_t st_d, st_q;
    logic             src_tick;
    logic [DIV_W-1:0] limit;
    logic             wrap;

    always_comb begin
        src_tick = use_fast ? tick_fast : tick_slow;
        limit    = (DIV_W'(1) << pre_code) - DIV_W'(1);
        wrap     = (st_q.phase >= limit);
        pre_tick = run && src_tick && wrap;

        st_d = st_q;
        if (!run) begin
            st_d.phase = '0;
        end else if (src_tick) begin
            st_d.phase = wrap ? '0 : st_q.phase + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: prescale phase restarts while stopped
    assert_pre_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> st_q.phase == '0);

    // R5: phase advances only on the selected source
    assert_pre_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !(use_fast ? tick_fast : tick_slow)) |=> $stable(st_q.phase));

endmodule

// File: rtl/timer_countdown.sv
module timer_countdown #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload_mode,
    input  logic             pre_tick,
    input  logic             cur_wr,
    input  logic [WIDTH-1:0] cur_wdata,
    input  logic [WIDTH-1:0] interval,
    output logic [WIDTH-1:0] count,
    output logic             expire,
    output logic             halt
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic   step;
    logic   at_zero;

    always_comb begin
        step    = run && pre_tick && !cur_wr;
        at_zero = (st_q.cnt == '0);
        expire  = step && (st_q.cnt == WIDTH'(1));
        halt    = step && at_zero && !reload_mode;

        st_d = st_q;
        if (cur_wr) begin
            st_d.cnt = cur_wdata;
        end else if (step) begin
            if (!at_zero)         st_d.cnt = st_q.cnt - WIDTH'(1);
            else if (reload_mode) st_d.cnt = interval;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R3: one step per prescaled tick
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pre_tick && !cur_wr && st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - WIDTH'(1));

    // R3: no tick, no write, no change
    assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_wr && !(run && pre_tick)) |=> $stable(st_q.cnt));

    // R7: reload from interval at zero
    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pre_tick && !cur_wr && st_q.cnt == '0 && reload_mode) |=> st_q.cnt == $past(interval));

    // R11: direct write wins
    assert_wr_prio_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> st_q.cnt == $past(cur_wdata));

endmodule

// File: rtl/timer_regs.sv
module timer_regs
    import timer_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wdata,
    input  logic             expire,
    input  logic             halt,
    output logic             ie,
    output logic             stat,
    output logic             run,
    output logic             reload,
    output logic             fast,
    output logic [PRE_W-1:0] pre,
    output logic [WIDTH-1:0] interval
);
    typedef struct packed {
        logic             ie;
        logic             stat;
        logic             run;
        logic             reload;
        logic             fast;
        logic [PRE_W-1:0] pre;
        logic [WIDTH-1:0] ival;
    } state_t;

    state_t st_d, st_q;
    logic   ctrl_wr;
    logic   stat_clr;

    always_comb begin
        ctrl_wr  = wr_en && (sel == SEL_CTRL);
        stat_clr = wr_en && (sel == SEL_STAT) && wdata[0];

        st_d = st_q;
        if (wr_en) begin
            case (sel)
                SEL_IE:   st_d.ie = wdata[0];
                SEL_CTRL: begin
                    st_d.run    = wdata[CB_RUN];
                    st_d.reload = wdata[CB_RELOAD];
                    st_d.fast   = wdata[CB_FAST];
                    st_d.pre    = wdata[CB_PRE_LSB +: PRE_W];
                end
                SEL_IVAL: st_d.ival = wdata;
                default:  ;
            endcase
        end
        if (halt && !ctrl_wr) st_d.run  = 1'b0;
        if (stat_clr)         st_d.stat = 1'b0;
        if (expire)           st_d.stat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ie       = st_q.ie;
    assign stat     = st_q.stat;
    assign run      = st_q.run;
    assign reload   = st_q.reload;
    assign fast     = st_q.fast;
    assign pre      = st_q.pre;
    assign interval = st_q.ival;

    // R6: pending flag only rises after an expiry
    assert_stat_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.stat) |-> $past(expire));

    // R10: expiry beats a same-cycle clear
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> st_q.stat);

    // R8: one-shot stop clears run
    assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !ctrl_wr) |=> !st_q.run);

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import timer_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned PRE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic              tick_slow,
    input  logic              tick_fast,
    output logic              irq
);
    reg_sel_e         sel;
    logic             wr_en;
    logic             cur_wr;
    logic             ie, stat, run, reload, fast;
    logic [PRE_W-1:0] pre;
    logic [WIDTH-1:0] interval;
    logic [WIDTH-1:0] count;
    logic             pre_tick;
    logic             expire, halt;

    always_comb begin
        sel    = decode_addr(bus_addr);
        wr_en  = bus_sel && bus_wr;
        cur_wr = wr_en && (sel == SEL_CUR);
    end

    timer_regs #(.WIDTH(WIDTH), .PRE_W(PRE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel      (sel),
        .wdata    (bus_wdata),
        .expire   (expire),
        .halt     (halt),
        .ie       (ie),
        .stat     (stat),
        .run      (run),
        .reload   (reload),
        .fast     (fast),
        .pre      (pre),
        .interval (interval)
    );

    timer_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .use_fast  (fast),
        .pre_code  (pre),
        .tick_slow (tick_slow),
        .tick_fast (tick_fast),
        .pre_tick  (pre_tick)
    );

    timer_countdown #(.WIDTH(WIDTH)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .reload_mode (reload),
        .pre_tick    (pre_tick),
        .cur_wr      (cur_wr),
        .cur_wdata   (bus_wdata),
        .interval    (interval),
        .count       (count),
        .expire      (expire),
        .halt        (halt)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_IE:   bus_rdata[0] = ie;
            SEL_STAT: bus_rdata[0] = stat;
            SEL_CTRL: begin
                bus_rdata[CB_RUN]             = run;
                bus_rdata[CB_RELOAD]          = reload;
                bus_rdata[CB_FAST]            = fast;
                bus_rdata[CB_PRE_LSB +: PRE_W] = pre;
            end
            SEL_IVAL: bus_rdata = interval;
            SEL_CUR:  bus_rdata = count;
            default:  bus_rdata = '0;
        endcase
        irq = ie && stat;
    end

endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        tick_slow = 1'b0;
    logic        tick_fast = 1'b0;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [7:0] A_IE = 8'h00, A_ST = 8'h04, A_CT = 8'h10,
                           A_IV = 8'h14, A_CU = 8'h18;

    always #4 clk = ~clk;

    interval_timer i_interval_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_slow(tick_slow), .tick_fast(tick_fast), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // write with optional same-cycle ticks; called just after a negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d,
                      input bit tf = 1'b0, input bit ts = 1'b0);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick_fast = tf; tick_slow = ts;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_fast = 1'b0; tick_slow = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input bit tf, input bit ts, input int n = 1);
        for (int i = 0; i < n; i++) begin
            tick_fast = tf; tick_slow = ts;
            @(posedge clk); @(negedge clk);
            tick_fast = 1'b0; tick_slow = 1'b0;
        end
    endtask

    task automatic t_reset();
        rd_chk("R1 ie", A_IE, 0);
        rd_chk("R1 status", A_ST, 0);
        rd_chk("R1 ctrl", A_CT, 0);
        rd_chk("R1 interval", A_IV, 0);
        rd_chk("R1 count", A_CU, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_regmap();
        wr(A_IE, 1);          rd_chk("R2 ie", A_IE, 1);
        wr(A_CT, 32'h76);     rd_chk("R2 ctrl", A_CT, 32'h76);
        wr(A_CT, 0);
        wr(A_IV, 32'hDEADBEEF); rd_chk("R2 interval", A_IV, 32'hDEADBEEF);
        wr(8'h08, 32'hFFFF_FFFF); rd_chk("R2 unmapped", 8'h08, 0);
        wr(A_IE, 0);
    endtask

    task automatic t_decrement();
        wr(A_CU, 5);
        wr(A_CT, 32'h05);
        pulse(1, 0, 3);       rd_chk("R3 R12 live count", A_CU, 2);
        pulse(0, 1);          rd_chk("R5 slow ignored", A_CU, 2);
        pulse(0, 0, 2);       rd_chk("R3 no tick holds", A_CU, 2);
        wr(A_CT, 0);
        pulse(1, 0);          rd_chk("R3 stopped holds", A_CU, 2);
    endtask

    task automatic t_source();
        wr(A_CU, 4);
        wr(A_CT, 32'h01);
        pulse(1, 0);          rd_chk("R5 fast ignored", A_CU, 4);
        pulse(0, 1);          rd_chk("R5 slow counts", A_CU, 3);
        wr(A_CT, 0);
    endtask

    task automatic t_prescale();
        wr(A_CU, 10);
        wr(A_CT, 32'h21);
        pulse(0, 1, 3);       rd_chk("R4 before boundary", A_CU, 10);
        pulse(0, 1);          rd_chk("R4 fourth tick", A_CU, 9);
        pulse(0, 1, 4);       rd_chk("R4 next group", A_CU, 8);
        wr(A_CT, 0);
    endtask

    task automatic t_oneshot();
        wr(A_ST, 1);
        wr(A_IE, 1);
        wr(A_CU, 2);
        wr(A_CT, 32'h05);
        pulse(1, 0);          rd_chk("R6 no early flag", A_ST, 0);
        pulse(1, 0);          rd_chk("R6 flag at zero", A_ST, 1);
        chk("R9 irq on", {31'b0, irq}, 1);
        rd_chk("R8 still running at zero", A_CT, 32'h05);
        pulse(1, 0);          rd_chk("R8 run cleared", A_CT, 32'h04);
        rd_chk("R8 count rests", A_CU, 0);
        pulse(1, 0);          rd_chk("R8 stays stopped", A_CU, 0);
        wr(A_IE, 0);
        chk("R9 masked", {31'b0, irq}, 0);
        wr(A_ST, 0);          rd_chk("R10 write 0 no effect", A_ST, 1);
        wr(A_ST, 1);          rd_chk("R10 w1c", A_ST, 0);
    endtask

    task automatic t_autoreload();
        wr(A_CT, 0);
        wr(A_IV, 3);
        wr(A_CU, 1);
        wr(A_CT, 32'h07);
        pulse(1, 0);          rd_chk("R6 auto flag", A_ST, 1);
        pulse(1, 0);          rd_chk("R7 reload", A_CU, 3);
        rd_chk("R7 still running", A_CT, 32'h07);
        pulse(1, 0, 3);       rd_chk("R7 down again", A_CU, 0);
        pulse(1, 0);          rd_chk("R7 second reload", A_CU, 3);
        wr(A_CT, 0);
        wr(A_ST, 1);
    endtask

    task automatic t_priority();
        wr(A_CU, 10);
        wr(A_CT, 32'h05);
        wr(A_CU, 50, 1'b1);   rd_chk("R11 write beats tick", A_CU, 50);
        wr(A_CT, 0);
        wr(A_IV, 2);
        wr(A_CU, 5);
        wr(A_CT, 32'h07);
        pulse(1, 0, 4);       rd_chk("R11 first delay no flag", A_ST, 0);
        pulse(1, 0);          rd_chk("R11 first expiry", A_ST, 1);
        wr(A_ST, 1);
        pulse(1, 0, 2);       rd_chk("R11 after reload", A_CU, 1);
        rd_chk("R11 period pending none", A_ST, 0);
        pulse(1, 0);          rd_chk("R11 second expiry", A_ST, 1);
        wr(A_CT, 0);
        wr(A_ST, 1);
    endtask

    task automatic t_setwins();
        wr(A_CU, 1);
        wr(A_CT, 32'h05);
        wr(A_ST, 1, 1'b1);    rd_chk("R10 set wins over clear", A_ST, 1);
        rd_chk("R10 count reached zero", A_CU, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_decrement();
        t_source();
        t_prescale();
        t_oneshot();
        t_autoreload();
        t_priority();
        t_setwins();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule